// File: doc/BRIEF.md
# Dual-Channel Serial Gain-Control Port

This block is the digital control side of a two-channel programmable-gain amplifier. Each channel has its own serial clock, active-low latch, serial data input, serial data output and channel enable. A host holds the latch low and clocks in an 8-bit command frame. The first bit chooses write (1) or read (0). The second bit carries no meaning. The last six bits are the gain code, least significant bit first. A write loads the 6-bit gain register when the latch returns high, but only if the whole frame has arrived. A read shifts the stored code back out on the data output, least significant bit first, and each output bit changes on a falling clock edge.

Each channel turns its stored code into a signed dB figure and a mute flag, which steer the analog attenuator and vernier. Codes 1 to 42 span −9 dB to +32 dB in 1 dB steps. Code 0 and codes 43 to 63 mute the path. Dropping the enable mutes the channel but keeps the stored code. The serial pins are asynchronous to the system clock. Each channel passes them through a synchronizer and detects serial clock edges in the system clock domain.

The frame controller in each channel is a state machine with five states:
- ST_IDLE waits for the latch to go low, then moves to ST_MODE.
- ST_MODE takes the first rising serial clock edge and goes to ST_WRITE if the bit is 1 or to ST_READ if it is 0.
- ST_WRITE shifts in seven more bits: the ignored bit and then the six code bits. It moves to ST_WFULL on the seventh.
- ST_WFULL waits for the latch to rise, commits the code and returns to ST_IDLE.
- ST_READ drives the output bits until the latch rises.

A latch rise in any state except ST_WFULL returns the machine to ST_IDLE and commits nothing.

Top module: `dual_gain_ctrl`

## Requirements
- R1: After reset every channel holds gain code 0, has its mute output high and its dB output at −64, and drives its serial data output low.
- R2: While a channel's latch is high, serial clock and data activity changes neither its stored code nor its data output, which stays low.
- R3: In a frame, first bit 1 means write and 0 means read. The second bit is ignored. The next six bits are the code, bit 0 first. Data is sampled on rising serial clock edges.
- R4: A write commits when the latch rises after at least eight rising edges. Bits after the eighth are ignored. A frame with fewer than eight edges leaves the code unchanged.
- R5: In a read frame, gain bit k appears on the data output after the falling edge that follows rising edge k+2 of the frame, counting from 1. A read never changes the stored code.
- R6: The serial data output returns low once the latch rises.
- R7: For codes 1 to 42 with the channel enabled, mute is low and the dB output equals the code minus 10 as a 7-bit two's-complement value.
- R8: For code 0 and codes 43 to 63, mute is high and the dB output is −64.
- R9: Enable low forces mute high and the dB output to −64. The code output keeps its value, and the serial port stays usable. Raising enable again restores the decoded gain of the stored code.
- R10: Traffic on one channel's serial pins never changes the other channel's code or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 2 | Serial clock, one bit per channel |
| ser_lat_n | input | 2 | Active-low frame latch, one bit per channel |
| ser_din | input | 2 | Serial data input, one bit per channel |
| ch_en | input | 2 | Channel enable, one bit per channel |
| ser_dout | output | 2 | Serial data output, one bit per channel |
| gain_code | output | 12 | Stored 6-bit gain code per channel, channel 0 in bits 5:0 |
| gain_db | output | 14 | Signed 7-bit gain in dB per channel, channel 0 in bits 6:0 |
| mute | output | 2 | Path-off flag per channel |

## Verification
A write-then-read sweep over all 64 codes, with the ignored bit toggling, checks the bit order in both directions. The read-back value exposes any reversal or offset, and the decoded outputs separate the in-range codes from the two muted bands at the boundaries 0/1 and 42/43. Short frames, long frames and clocking with the latch high each test the commit rule apart from the shifting. Random frames mixed across both channels check that the channels stay independent. An enable toggle with a write in between shows that power-down only masks the decode.

// File: rtl/gainctl_pkg.sv
package gainctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_WRITE,
        ST_WFULL,
        ST_READ
    } port_state_t;

endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/frame_engine.sv
module frame_engine
    import gainctl_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              lat_n_s,
    input  logic              din_s,
    output logic [CODE_W-1:0] gain_q,
    output logic              sdo_q
);
    localparam int CNT_W = $clog2(CODE_W + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CODE_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    port_state_t       state, nxt;
    logic              sclk_d;
    logic              s_rise, s_fall, lat_low;
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] wr_sh, rd_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign s_rise  = sclk_s & ~sclk_d;
    assign s_fall  = ~sclk_s & sclk_d;
    assign lat_low = ~lat_n_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (lat_low) nxt = ST_MODE;
            ST_MODE: begin
                if (!lat_low)    nxt = ST_IDLE;
                else if (s_rise) nxt = din_s ? ST_WRITE : ST_READ;
            end
            ST_WRITE: begin
                if (!lat_low)                      nxt = ST_IDLE;
                else if (s_rise && cnt == CNT_LAST) nxt = ST_WFULL;
            end
            ST_WFULL: if (!lat_low) nxt = ST_IDLE;
            ST_READ:  if (!lat_low) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            wr_sh  <= '0;
            rd_sh  <= '0;
            gain_q <= '0;
            sdo_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt   <= '0;
                    sdo_q <= 1'b0;
                end
                ST_MODE: begin
                    if (lat_low && s_rise) begin
                        cnt   <= '0;
                        rd_sh <= gain_q;
                    end
                end
                ST_WRITE: begin
                    if (lat_low && s_rise) begin
                        wr_sh <= {din_s, wr_sh[CODE_W-1:1]};
                        cnt   <= cnt + CNT_ONE;
                    end
                end
                ST_WFULL: begin
                    if (!lat_low) gain_q <= wr_sh;
                end
                ST_READ: begin
                    if (!lat_low) begin
                        sdo_q <= 1'b0;
                    end else begin
                        if (s_rise && cnt <= CNT_LAST) cnt <= cnt + CNT_ONE;
                        if (s_fall && cnt >= CNT_ONE && cnt <= CNT_LAST) begin
                            sdo_q <= rd_sh[0];
                            rd_sh <= rd_sh >> 1;
                        end
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R4
    gain_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_q != $past(gain_q)) |-> ($past(state) == ST_WFULL && $past(lat_n_s)));

    // R5
    sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_q != $past(sdo_q)) |-> $past(s_fall || lat_n_s));

    // R6
    idle_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sdo_q);
endmodule

// File: rtl/gain_decode.sv
module gain_decode #(
    parameter int CODE_W  = 6,
    parameter int DB_W    = 7,
    parameter int CODE_LO = 1,
    parameter int CODE_HI = 42,
    parameter int OFFSET  = 10
) (
    input  logic                   en,
    input  logic [CODE_W-1:0]      code,
    output logic signed [DB_W-1:0] db,
    output logic                   mute
);
    localparam logic [CODE_W-1:0]      LO_C    = CODE_W'(CODE_LO);
    localparam logic [CODE_W-1:0]      HI_C    = CODE_W'(CODE_HI);
    localparam logic signed [DB_W-1:0] OFS     = DB_W'(OFFSET);
    localparam logic signed [DB_W-1:0] MUTE_DB = {1'b1, {(DB_W-1){1'b0}}};

    logic                   in_range;
    logic signed [DB_W-1:0] code_ext;

    always_comb begin
        in_range = (code >= LO_C) && (code <= HI_C);
        mute     = !(en && in_range);
        code_ext = DB_W'(code);
        db       = mute ? MUTE_DB : (code_ext - OFS);
    end
endmodule

// File: rtl/gain_port_chan.sv
module gain_port_chan #(
    parameter int CODE_W      = 6,
    parameter int DB_W        = 7,
    parameter int SYNC_STAGES = 2,
    parameter int CODE_LO     = 1,
    parameter int CODE_HI     = 42,
    parameter int OFFSET      = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   lat_n,
    input  logic                   din,
    input  logic                   en,
    output logic                   dout,
    output logic [CODE_W-1:0]      code,
    output logic signed [DB_W-1:0] db,
    output logic                   mute
);
    logic [3:0] pins_s;

    sig_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, lat_n, din, en}),
        .q     (pins_s)
    );

    frame_engine #(.CODE_W(CODE_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[3]),
        .lat_n_s (pins_s[2]),
        .din_s   (pins_s[1]),
        .gain_q  (code),
        .sdo_q   (dout)
    );

    gain_decode #(
        .CODE_W  (CODE_W),
        .DB_W    (DB_W),
        .CODE_LO (CODE_LO),
        .CODE_HI (CODE_HI),
        .OFFSET  (OFFSET)
    ) u_dec (
        .en   (pins_s[0]),
        .code (code),
        .db   (db),
        .mute (mute)
    );

    // R7
    db_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mute |-> (db >= (CODE_LO - OFFSET) && db <= (CODE_HI - OFFSET)));

    // R9
    mute_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_s[0] |-> mute);
endmodule

// File: rtl/dual_gain_ctrl.sv
module dual_gain_ctrl #(
    parameter int NCH         = 2,
    parameter int CODE_W      = 6,
    parameter int DB_W        = 7,
    parameter int SYNC_STAGES = 2,
    parameter int CODE_LO     = 1,
    parameter int CODE_HI     = 42,
    parameter int OFFSET      = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ser_clk,
    input  logic [NCH-1:0]        ser_lat_n,
    input  logic [NCH-1:0]        ser_din,
    input  logic [NCH-1:0]        ch_en,
    output logic [NCH-1:0]        ser_dout,
    output logic [NCH*CODE_W-1:0] gain_code,
    output logic [NCH*DB_W-1:0]   gain_db,
    output logic [NCH-1:0]        mute
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [DB_W-1:0] db_c;

        gain_port_chan #(
            .CODE_W      (CODE_W),
            .DB_W        (DB_W),
            .SYNC_STAGES (SYNC_STAGES),
            .CODE_LO     (CODE_LO),
            .CODE_HI     (CODE_HI),
            .OFFSET      (OFFSET)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .sclk  (ser_clk[c]),
            .lat_n (ser_lat_n[c]),
            .din   (ser_din[c]),
            .en    (ch_en[c]),
            .dout  (ser_dout[c]),
            .code  (gain_code[c*CODE_W +: CODE_W]),
            .db    (db_c),
            .mute  (mute[c])
        );

        assign gain_db[c*DB_W +: DB_W] = db_c;
    end
endmodule

// File: tb/sim_dual_gain_ctrl.sv
module sim_dual_gain_ctrl;
    localparam int HALF = 6;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ser_clk = 2'b00;
    logic [1:0]  ser_lat_n = 2'b11;
    logic [1:0]  ser_din = 2'b00;
    logic [1:0]  ch_en = 2'b11;
    logic [1:0]  ser_dout;
    logic [11:0] gain_code;
    logic [13:0] gain_db;
    logic [1:0]  mute;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    int exp_code [2];

    always #4 clk = ~clk;

    dual_gain_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_lat_n (ser_lat_n),
        .ser_din   (ser_din),
        .ch_en     (ch_en),
        .ser_dout  (ser_dout),
        .gain_code (gain_code),
        .gain_db   (gain_db),
        .mute      (mute)
    );

    function automatic int f_mute(input int code, input bit en);
        return (!en || code == 0 || code > 42) ? 1 : 0;
    endfunction

    function automatic int f_db(input int code, input bit en);
        return f_mute(code, en) ? -64 : code - 10;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_chan(input string req, input int ch, input int code, input bit en);
        chk(req, $sformatf("ch%0d code", ch), int'(gain_code[ch*6 +: 6]), code);
        chk(req, $sformatf("ch%0d mute", ch), int'(mute[ch]), f_mute(code, en));
        chk(req, $sformatf("ch%0d db", ch), int'($signed(gain_db[ch*7 +: 7])), f_db(code, en));
    endtask

    // frame bit i is frm[i]: frm[0] mode, frm[1] ignored, frm[7:2] code LSB first
    task automatic xfer(input int ch, input logic [7:0] frm, input int nbits,
                        output logic [5:0] rd);
        rd = '0;
        ser_lat_n[ch] = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            ser_din[ch] = (i < 8) ? frm[i % 8] : 1'b1;
            tick(HALF);
            if (i >= 2 && i < 8) rd[i-2] = ser_dout[ch];
            ser_clk[ch] = 1'b1;
            tick(HALF);
            ser_clk[ch] = 1'b0;
        end
        tick(HALF);
        ser_lat_n[ch] = 1'b1;
        ser_din[ch] = 1'b0;
        tick(10);
    endtask

    task automatic wr(input int ch, input int code, input bit dc, input int nbits);
        logic [5:0] rd;
        xfer(ch, {6'(code), dc, 1'b1}, nbits, rd);
    endtask

    task automatic rdc(input int ch, input bit dc, input int nbits, output int val);
        logic [5:0] rd;
        xfer(ch, {6'b101010, dc, 1'b0}, nbits, rd);
        val = int'(rd);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT) begin
                errors++;
                checks++;
                $display("FAIL R1 watchdog actual=%0d expected below %0d", cycles, WD_LIMIT);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int v;
        int v2;
        void'($urandom(32'h1c3a5e07));
        exp_code[0] = 0;
        exp_code[1] = 0;
        tick(5);
        rst_n = 1'b1;
        tick(6);

        // R1 reset state
        for (int ch = 0; ch < 2; ch++) begin
            chk_chan("R1", ch, 0, 1'b1);
            chk("R1", $sformatf("ch%0d sdo", ch), int'(ser_dout[ch]), 0);
        end

        // R3 R5 R7 R8 R10 sweep of every code on both channels
        for (int c = 0; c < 64; c++) begin
            wr(0, c, c[0], 8);
            exp_code[0] = c;
            chk("R10", "ch1 code after ch0 write", int'(gain_code[11:6]), exp_code[1]);
            wr(1, 63 - c, ~c[1], 8);
            exp_code[1] = 63 - c;
            rdc(0, c[2], 8, v);
            chk("R5", "ch0 readback", v, c);
            rdc(1, c[3], 8, v);
            chk("R5", "ch1 readback", v, 63 - c);
            chk_chan((c >= 1 && c <= 42) ? "R7" : "R8", 0, c, 1'b1);
            chk_chan(((63 - c) >= 1 && (63 - c) <= 42) ? "R7" : "R8", 1, 63 - c, 1'b1);
            chk("R6", "sdo after read", int'(ser_dout), 0);
        end

        // R3 boundary codes with ignored bit set either way
        wr(0, 1, 1'b1, 8);  exp_code[0] = 1;  chk_chan("R3", 0, 1, 1'b1);
        wr(0, 42, 1'b0, 8); exp_code[0] = 42; chk_chan("R3", 0, 42, 1'b1);
        wr(0, 43, 1'b1, 8); exp_code[0] = 43; chk_chan("R8", 0, 43, 1'b1);

        // R4 short write frames are dropped
        wr(0, 17, 1'b0, 8); exp_code[0] = 17;
        for (int n = 1; n < 8; n++) begin
            wr(0, 33, 1'b1, n);
            chk_chan("R4", 0, 17, 1'b1);
        end
        // R4 long write frame keeps the first eight bits
        wr(0, 29, 1'b0, 11); exp_code[0] = 29;
        chk_chan("R4", 0, 29, 1'b1);

        // R5 read is non-destructive, short read leaves code and sdo low
        rdc(0, 1'b0, 8, v);
        rdc(0, 1'b1, 8, v2);
        chk("R5", "repeated read", v2, 29);
        rdc(0, 1'b0, 4, v);
        chk_chan("R5", 0, 29, 1'b1);
        chk("R6", "sdo after short read", int'(ser_dout[0]), 0);

        // R2 clocking with latch high
        for (int i = 0; i < 16; i++) begin
            ser_din[0] = i[0] | i[2];
            tick(HALF);
            ser_clk[0] = 1'b1;
            tick(HALF);
            chk("R2", "sdo with latch high", int'(ser_dout[0]), 0);
            ser_clk[0] = 1'b0;
        end
        tick(10);
        chk_chan("R2", 0, 29, 1'b1);

        // R9 enable masks decode, keeps code, port still usable
        ch_en[0] = 1'b0;
        tick(8);
        chk_chan("R9", 0, 29, 1'b0);
        chk_chan("R10", 1, exp_code[1], 1'b1);
        wr(0, 35, 1'b0, 8); exp_code[0] = 35;
        chk_chan("R9", 0, 35, 1'b0);
        ch_en[0] = 1'b1;
        tick(8);
        chk_chan("R9", 0, 35, 1'b1);

        // random frames on both channels against the model
        for (int it = 0; it < 60; it++) begin
            int ch;
            int code;
            int nb;
            bit is_wr;
            ch = int'($urandom_range(0, 1));
            code = int'($urandom_range(0, 63));
            is_wr = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0: nb = int'($urandom_range(1, 7));
                1: nb = int'($urandom_range(9, 12));
                default: nb = 8;
            endcase
            if (is_wr) begin
                wr(ch, code, 1'($urandom_range(0, 1)), nb);
                if (nb >= 8) exp_code[ch] = code;
                chk_chan(nb >= 8 ? "R3" : "R4", ch, exp_code[ch], 1'b1);
            end else begin
                rdc(ch, 1'($urandom_range(0, 1)), nb, v);
                if (nb >= 8) chk("R5", "random readback", v, exp_code[ch]);
                chk_chan("R5", ch, exp_code[ch], 1'b1);
            end
            chk_chan("R10", 1 - ch, exp_code[1 - ch], 1'b1);
            chk("R6", "sdo idle", int'(ser_dout), 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule